// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block produces the row-scan and frame timing for a passive-matrix graphic LCD with 17 common lines, 120 segment lines and three static icon outputs. It runs from the display clock, nominally 38.4 kHz. A frame is 640 clocks long, which gives a 60 Hz frame rate. Within each frame the block walks through the common lines at either 1/16 or 1/17 duty. For each line it fetches one 120-bit row from an external 17x120 display RAM over a synchronous read port. The returned bits are held in an output latch that drives the segment lines. Row order and column order can each be reversed. A low-power icon mode shows only the last common line. A display-off state blanks the matrix.

All outputs are logical. Each common and segment output is a select bit. A frame polarity bit tells a downstream level selector when to swap drive levels. A separate backplane runs at half the frame rate, and three icon outputs toggle either against it or with it. The mode inputs are sampled once per frame, at the frame boundary, so a frame never mixes two settings. The reset input is asynchronous and active low. Its deassertion must be synchronous to `clk`.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset all outputs are low. The active settings are 1/17 duty, no re-mapping, display off and icon mode off. These stay in force until the first frame boundary, 640 clocks after reset release, whatever the mode inputs are.
- R2: An internal scan count c advances once per clock and wraps at 640; c is 0 in the first cycle after reset release. Mode inputs are captured at the wrap, and the new frame uses them. `frame_pol` toggles exactly once per frame, in step with the first row of each frame appearing at the outputs.
- R3: At 1/16 duty (`cfg_duty17`=0) the frame is 16 slots of 40 clocks. Slot k selects COM k (bit k of `com_sel`) and shows RAM row k. COM16 is never selected.
- R4: At 1/17 duty the frame is 17 slots of 37 clocks, followed by 11 idle clocks. During the idle clocks no common line is selected and all segments are low.
- R5: At most one bit of `com_sel` is set in any cycle.
- R6: With row re-map, slot k selects COM(N-1-k), where N is 16 or 17 lines, and still shows RAM row k.
- R7: Bit j of `ram_rd_data` is column j. Without column re-map, `seg_on[j]` shows column j. With column re-map, `seg_on[j]` shows column 119-j.
- R8: For a slot starting at scan count s, `ram_rd_en` is high for one cycle at count s, with `ram_rd_addr` set to the row. The data must return one cycle later. `com_sel` and `seg_on` switch two cycles after that request and change at no other time.
- R9: In icon mode, 17-slot timing is used regardless of `cfg_duty17`. Only slot 16 is active: it selects COM16 and shows RAM row 16. This is the only RAM read in the frame, and row re-map has no effect.
- R10: With display off, `com_sel` and `seg_on` stay low and no RAM read is issued. The backplane and icon outputs keep running.
- R11: `bp_out` has a period of 1280 clocks and a 50% duty cycle. It toggles in the cycle where the scan count reaches 320.
- R12: Each `ann_out[i]` is the inverse of `bp_out` when `ann_en[i]` is 1 and equal to `bp_out` when it is 0. A change of `ann_en[i]` takes effect one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_duty17 | input | 1 | 1 selects 1/17 duty, 0 selects 1/16 |
| cfg_row_flip | input | 1 | Reverse common-line order |
| cfg_col_flip | input | 1 | Mirror segment order |
| cfg_disp_on | input | 1 | Matrix display enable |
| cfg_icon | input | 1 | Low-power icon mode (last common line only) |
| ann_en | input | 3 | Icon output enables |
| ram_rd_en | output | 1 | Display RAM read request |
| ram_rd_addr | output | 5 | Display RAM row address |
| ram_rd_data | input | 120 | Row data, valid one cycle after the request |
| com_sel | output | 17 | Common-line select bits |
| seg_on | output | 120 | Segment on bits |
| frame_pol | output | 1 | Frame drive polarity |
| bp_out | output | 1 | Icon backplane |
| ann_out | output | 3 | Icon segment outputs |

## Verification
The bench sweeps the mode inputs across 1/16 and 1/17 duty. It tries each duty with row re-map, column re-map, both together, icon mode with re-maps set, and display off. It compares every output against an arithmetic model in every cycle of at least one full frame per setting.

Every RAM row holds a distinct pattern that is not symmetric. This way a wrong row, a wrong mirror or an off-by-one slot boundary each produce a different mismatch. The mode inputs change in the middle of frames, which separates frame-boundary sampling from immediate use. The icon enables change between settings, so both the in-phase and the antiphase relation are seen through several backplane periods.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int unsigned COM_LINES  = 17;
  localparam int unsigned SEG_LINES  = 120;
  localparam int unsigned ANN_LINES  = 3;
  localparam int unsigned FRAME_CLKS = 640;

  typedef struct packed {
    logic duty17;
    logic row_flip;
    logic col_flip;
    logic disp_on;
    logic icon;
  } scan_cfg_t;

  localparam scan_cfg_t CFG_RESET = '{
    duty17:   1'b1,
    row_flip: 1'b0,
    col_flip: 1'b0,
    disp_on:  1'b0,
    icon:     1'b0
  };

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NCOM  = COM_LINES,
  parameter int unsigned FRAME = FRAME_CLKS,
  localparam int unsigned CNT_W    = $clog2(FRAME),
  localparam int unsigned IDX_W    = $clog2(NCOM + 1),
  localparam int unsigned LEN_ALL  = FRAME / NCOM,
  localparam int unsigned LEN_TRIM = FRAME / (NCOM - 1),
  localparam int unsigned POS_W    = $clog2(LEN_TRIM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scan_cfg_t        cfg_in,
  output scan_cfg_t        cfg_q,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [IDX_W-1:0] slot_idx,
  output logic             slot_bound,
  output logic             pol
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pol_q, pol_d;
  scan_cfg_t        cfg_r;
  logic             frame_end;
  logic             long_mode;
  logic [POS_W-1:0] slot_len;
  logic [IDX_W-1:0] nslots;
  logic             slot_wrap;

  // Slot geometry of the frame now running
  always_comb begin
    long_mode = cfg_r.duty17 | cfg_r.icon;
    slot_len  = long_mode ? POS_W'(LEN_ALL) : POS_W'(LEN_TRIM);
    nslots    = long_mode ? IDX_W'(NCOM) : IDX_W'(NCOM - 1);
  end

  // Next-state logic
  always_comb begin
    frame_end = (cnt_q == CNT_W'(FRAME - 1));
    slot_wrap = (pos_q == slot_len - POS_W'(1));
    cnt_d     = frame_end ? '0 : cnt_q + CNT_W'(1);
    pol_d     = pol_q ^ frame_end;
    if (frame_end) begin
      pos_d = '0;
      idx_d = '0;
    end else if (slot_wrap) begin
      pos_d = '0;
      idx_d = (idx_q == nslots) ? idx_q : idx_q + IDX_W'(1);
    end else begin
      pos_d = pos_q + POS_W'(1);
      idx_d = idx_q;
    end
  end

  // Counter registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
      idx_q <= '0;
      pol_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
      idx_q <= idx_d;
      pol_q <= pol_d;
    end
  end

  // Settings register, enabled once per frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= CFG_RESET;
    end else if (frame_end) begin
      cfg_r <= cfg_in;
    end
  end

  assign cfg_q      = cfg_r;
  assign frame_cnt  = cnt_q;
  assign slot_idx   = idx_q;
  assign slot_bound = (pos_q == '0);
  assign pol        = pol_q;

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (idx_q == '0 && pos_q == '0));

  // R2
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(pol_q));

  // R4
  slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= nslots);

endmodule

// File: rtl/lcd_row_mapper.sv
module lcd_row_mapper
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NCOM = COM_LINES,
  localparam int unsigned IDX_W  = $clog2(NCOM + 1),
  localparam int unsigned ADDR_W = $clog2(NCOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scan_cfg_t         cfg,
  input  logic [IDX_W-1:0]  slot_idx,
  input  logic              slot_bound,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_active,
  output logic [ADDR_W-1:0] cmd_com
);

  localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(NCOM - 1);

  logic             long_mode;
  logic [IDX_W-1:0] nslots;
  logic [IDX_W-1:0] flip_idx;

  always_comb begin
    long_mode = cfg.duty17 | cfg.icon;
    nslots    = long_mode ? IDX_W'(NCOM) : IDX_W'(NCOM - 1);
    flip_idx  = nslots - IDX_W'(1) - slot_idx;
    if (cfg.icon) begin
      cmd_active = cfg.disp_on && (slot_idx == IDX_W'(NCOM - 1));
      cmd_com    = LAST_ROW;
      rd_addr    = LAST_ROW;
    end else begin
      cmd_active = cfg.disp_on && (slot_idx < nslots);
      cmd_com    = cfg.row_flip ? ADDR_W'(flip_idx) : ADDR_W'(slot_idx);
      rd_addr    = ADDR_W'(slot_idx);
    end
    rd_en = slot_bound && cmd_active;
  end

  // R8
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= LAST_ROW));

  // R9
  icon_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cfg.icon) |-> (rd_addr == LAST_ROW && cmd_com == LAST_ROW));

  // R10
  off_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.disp_on |-> !rd_en);

endmodule

// File: rtl/lcd_seg_stage.sv
module lcd_seg_stage
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NCOM = COM_LINES,
  parameter int unsigned NSEG = SEG_LINES,
  localparam int unsigned ADDR_W = $clog2(NCOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bound,
  input  logic              active,
  input  logic [ADDR_W-1:0] com_idx,
  input  logic              col_flip,
  input  logic              pol_in,
  input  logic [NSEG-1:0]   rd_data,
  output logic [NCOM-1:0]   com_sel,
  output logic [NSEG-1:0]   seg_on,
  output logic              frame_pol
);

  logic              s1_bound;
  logic              s1_active;
  logic [ADDR_W-1:0] s1_com;
  logic              s1_flip;
  logic              s1_pol;
  logic [NSEG-1:0]   seg_pick;
  logic [NCOM-1:0]   com_dec;
  logic [NSEG-1:0]   seg_d;
  logic [NCOM-1:0]   com_d;
  logic [NSEG-1:0]   seg_q;
  logic [NCOM-1:0]   com_q;
  logic              pol_q;

  // Stage 1: slot command, aligned with the RAM read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_bound  <= 1'b0;
      s1_active <= 1'b0;
      s1_com    <= '0;
      s1_flip   <= 1'b0;
      s1_pol    <= 1'b0;
    end else begin
      s1_bound <= bound;
      s1_pol   <= pol_in;
      if (bound) begin
        s1_active <= active;
        s1_com    <= com_idx;
        s1_flip   <= col_flip;
      end
    end
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_mirror
    assign seg_pick[j] = s1_flip ? rd_data[NSEG-1-j] : rd_data[j];
  end

  for (genvar i = 0; i < NCOM; i++) begin : g_com_dec
    assign com_dec[i] = (s1_com == ADDR_W'(i));
  end

  always_comb begin
    com_d = s1_active ? com_dec  : '0;
    seg_d = s1_active ? seg_pick : '0;
  end

  // Stage 2: output latch, loaded only at slot boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_q <= '0;
      seg_q <= '0;
      pol_q <= 1'b0;
    end else begin
      pol_q <= s1_pol;
      if (s1_bound) begin
        com_q <= com_d;
        seg_q <= seg_d;
      end
    end
  end

  assign com_sel   = com_q;
  assign seg_on    = seg_q;
  assign frame_pol = pol_q;

  // R8
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_bound |=> ($stable(seg_q) && $stable(com_q)));

  // R5
  com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_q));

endmodule

// File: rtl/lcd_annun_drv.sv
module lcd_annun_drv
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NANN  = ANN_LINES,
  parameter int unsigned FRAME = FRAME_CLKS,
  localparam int unsigned CNT_W = $clog2(FRAME),
  localparam int unsigned HALF  = FRAME / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] frame_cnt,
  input  logic [NANN-1:0]  ann_en,
  output logic             bp,
  output logic [NANN-1:0]  ann
);

  logic            bp_q, bp_d;
  logic [NANN-1:0] ann_q, ann_d;

  always_comb begin
    bp_d  = bp_q ^ (frame_cnt == CNT_W'(HALF - 1));
    ann_d = ann_en ^ {NANN{bp_d}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q  <= 1'b0;
      ann_q <= '0;
    end else begin
      bp_q  <= bp_d;
      ann_q <= ann_d;
    end
  end

  assign bp  = bp_q;
  assign ann = ann_q;

  // R11
  bp_toggle_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_q) |-> (frame_cnt == CNT_W'(HALF)));

  // R12
  ann_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(ann_en)) |=>
      ((ann_q ^ {NANN{bp_q}}) == $past(ann_q ^ {NANN{bp_q}})));

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NCOM  = COM_LINES,
  parameter int unsigned NSEG  = SEG_LINES,
  parameter int unsigned NANN  = ANN_LINES,
  parameter int unsigned FRAME = FRAME_CLKS,
  localparam int unsigned ADDR_W = $clog2(NCOM),
  localparam int unsigned IDX_W  = $clog2(NCOM + 1),
  localparam int unsigned CNT_W  = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_duty17,
  input  logic              cfg_row_flip,
  input  logic              cfg_col_flip,
  input  logic              cfg_disp_on,
  input  logic              cfg_icon,
  input  logic [NANN-1:0]   ann_en,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [NSEG-1:0]   ram_rd_data,
  output logic [NCOM-1:0]   com_sel,
  output logic [NSEG-1:0]   seg_on,
  output logic              frame_pol,
  output logic              bp_out,
  output logic [NANN-1:0]   ann_out
);

  scan_cfg_t         cfg_in;
  scan_cfg_t         cfg_act;
  logic [CNT_W-1:0]  frame_cnt;
  logic [IDX_W-1:0]  slot_idx;
  logic              slot_bound;
  logic              sched_pol;
  logic              cmd_active;
  logic [ADDR_W-1:0] cmd_com;

  always_comb begin
    cfg_in.duty17   = cfg_duty17;
    cfg_in.row_flip = cfg_row_flip;
    cfg_in.col_flip = cfg_col_flip;
    cfg_in.disp_on  = cfg_disp_on;
    cfg_in.icon     = cfg_icon;
  end

  lcd_frame_timer #(.NCOM(NCOM), .FRAME(FRAME)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_in     (cfg_in),
    .cfg_q      (cfg_act),
    .frame_cnt  (frame_cnt),
    .slot_idx   (slot_idx),
    .slot_bound (slot_bound),
    .pol        (sched_pol)
  );

  lcd_row_mapper #(.NCOM(NCOM)) u_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg_act),
    .slot_idx   (slot_idx),
    .slot_bound (slot_bound),
    .rd_en      (ram_rd_en),
    .rd_addr    (ram_rd_addr),
    .cmd_active (cmd_active),
    .cmd_com    (cmd_com)
  );

  lcd_seg_stage #(.NCOM(NCOM), .NSEG(NSEG)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bound     (slot_bound),
    .active    (cmd_active),
    .com_idx   (cmd_com),
    .col_flip  (cfg_act.col_flip),
    .pol_in    (sched_pol),
    .rd_data   (ram_rd_data),
    .com_sel   (com_sel),
    .seg_on    (seg_on),
    .frame_pol (frame_pol)
  );

  lcd_annun_drv #(.NANN(NANN), .FRAME(FRAME)) u_annun (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_cnt (frame_cnt),
    .ann_en    (ann_en),
    .bp        (bp_out),
    .ann       (ann_out)
  );

endmodule

// File: tb/tb_lcd_scan_ctrl.sv
module tb_lcd_scan_ctrl;

  localparam int FR    = 640;
  localparam int NC    = 17;
  localparam int NS    = 120;
  localparam int L17   = FR / NC;
  localparam int L16   = FR / (NC - 1);
  localparam int B_DUTY = 4, B_RFL = 3, B_CFL = 2, B_DISP = 1, B_ICON = 0;
  localparam logic [4:0] DEF_CFG = 5'b10000;

  logic          clk, rst_n;
  logic          cfg_duty17, cfg_row_flip, cfg_col_flip, cfg_disp_on, cfg_icon;
  logic [2:0]    ann_en;
  logic          ram_rd_en;
  logic [4:0]    ram_rd_addr;
  logic [NS-1:0] ram_rd_data;
  logic [NC-1:0] com_sel;
  logic [NS-1:0] seg_on;
  logic          frame_pol, bp_out;
  logic [2:0]    ann_out;

  lcd_scan_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_duty17(cfg_duty17), .cfg_row_flip(cfg_row_flip), .cfg_col_flip(cfg_col_flip),
    .cfg_disp_on(cfg_disp_on), .cfg_icon(cfg_icon), .ann_en(ann_en),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .com_sel(com_sel), .seg_on(seg_on), .frame_pol(frame_pol),
    .bp_out(bp_out), .ann_out(ann_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int e;
  bit checking = 0;
  logic [4:0] sch_cfg, out_cfg;
  logic [2:0] ann_cap;
  logic [NS-1:0] ram [NC];

  // Distinct, asymmetric row patterns
  initial begin
    for (int r = 0; r < NC; r++)
      for (int j = 0; j < NS; j++)
        ram[r][j] = (((j * 7 + r * 3 + j / 5) % 4) == 0) ^ (r == (j % NC)) ^ (j < r);
  end

  always @(posedge clk) begin
    if (ram_rd_en) ram_rd_data <= (ram_rd_addr < NC) ? ram[ram_rd_addr] : '0;
  end

  function automatic logic [4:0] cur_cfg();
    return {cfg_duty17, cfg_row_flip, cfg_col_flip, cfg_disp_on, cfg_icon};
  endfunction

  // Bench time model: e counts rising edges since reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e       <= 0;
      sch_cfg <= DEF_CFG;
      out_cfg <= DEF_CFG;
      ann_cap <= '0;
    end else begin
      e <= e + 1;
      if ((e + 1) % FR == 0) sch_cfg <= cur_cfg();
      if ((e + 1) % FR == 2) out_cfg <= sch_cfg;
      ann_cap <= ann_en;
    end
  end

  task automatic slot_info(input int c, input logic [4:0] cfg,
                           output bit act, output bit bnd, output int com, output int row);
    bit lng;
    int len, ns, k;
    lng = cfg[B_DUTY] | cfg[B_ICON];
    len = lng ? L17 : L16;
    ns  = lng ? NC : NC - 1;
    k   = c / len;
    bnd = (c % len) == 0;
    com = 0;
    row = 0;
    if (!cfg[B_DISP]) act = 0;
    else if (cfg[B_ICON]) begin
      act = (k == NC - 1);
      com = NC - 1;
      row = NC - 1;
    end else begin
      act = (k < ns);
      row = k;
      com = cfg[B_RFL] ? (ns - 1 - k) : k;
    end
  endtask

  function automatic string tag_of(input int t, input logic [4:0] cfg);
    if (t < FR + 2) return "R1";
    if (!cfg[B_DISP]) return "R10";
    if (cfg[B_ICON]) return "R9";
    if (cfg[B_RFL]) return "R6";
    if (cfg[B_CFL]) return "R7";
    if (cfg[B_DUTY]) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, e, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      bit act, bnd;
      int com, row, c;
      logic [NC-1:0] exp_com;
      logic [NS-1:0] exp_seg;
      logic exp_pol, exp_bp;
      string tg;
      exp_com = '0;
      exp_seg = '0;
      exp_pol = 1'b0;
      if (e >= 2) begin
        c = (e - 2) % FR;
        slot_info(c, out_cfg, act, bnd, com, row);
        if (act) begin
          exp_com[com] = 1'b1;
          for (int j = 0; j < NS; j++)
            exp_seg[j] = out_cfg[B_CFL] ? ram[row][NS-1-j] : ram[row][j];
        end
        exp_pol = (((e - 2) / FR) % 2) == 1;
      end
      tg = tag_of(e, out_cfg);
      chk(tg, "com_sel", 128'(com_sel), 128'(exp_com));
      chk(tg, "seg_on", 128'(seg_on), 128'(exp_seg));
      chk("R5", "com count", 128'($countones(com_sel) <= 1), 128'(1));
      chk("R2", "frame_pol", 128'(frame_pol), 128'(exp_pol));
      exp_bp = (((e + FR / 2) / FR) % 2) == 1;
      chk("R11", "bp_out", 128'(bp_out), 128'(exp_bp));
      chk("R12", "ann_out", 128'(ann_out), 128'(ann_cap ^ {3{exp_bp}}));
      slot_info(e % FR, sch_cfg, act, bnd, com, row);
      chk("R8", "ram_rd_en", 128'(ram_rd_en), 128'(act && bnd));
      if (act && bnd) chk("R8", "ram_rd_addr", 128'(ram_rd_addr), 128'(row));
    end
  end

  task automatic set_cfg(input bit duty, input bit rfl, input bit cfl,
                         input bit disp, input bit icon, input logic [2:0] en);
    @(negedge clk);
    cfg_duty17   = duty;
    cfg_row_flip = rfl;
    cfg_col_flip = cfl;
    cfg_disp_on  = disp;
    cfg_icon     = icon;
    ann_en       = en;
    repeat (1300) @(negedge clk);
  endtask

  initial begin
    rst_n        = 1'b0;
    cfg_duty17   = 1'b0;
    cfg_row_flip = 1'b0;
    cfg_col_flip = 1'b0;
    cfg_disp_on  = 1'b1;
    cfg_icon     = 1'b0;
    ann_en       = 3'b101;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "com_sel", 128'(com_sel), 128'(0));
    chk("R1", "seg_on", 128'(seg_on), 128'(0));
    chk("R1", "frame_pol", 128'(frame_pol), 128'(0));
    chk("R1", "bp_out", 128'(bp_out), 128'(0));
    chk("R1", "ann_out", 128'(ann_out), 128'(0));
    chk("R1", "ram_rd_en", 128'(ram_rd_en), 128'(0));
    rst_n    = 1'b1;
    checking = 1;
    repeat (700) @(negedge clk);
    // R3 1/16 plain, R4 1/17 plain, R6 row re-map both duties
    set_cfg(0, 0, 0, 1, 0, 3'b101);
    set_cfg(1, 0, 0, 1, 0, 3'b010);
    set_cfg(1, 1, 0, 1, 0, 3'b111);
    set_cfg(0, 1, 0, 1, 0, 3'b000);
    // R7 column re-map, alone and with row re-map
    set_cfg(1, 0, 1, 1, 0, 3'b100);
    set_cfg(0, 1, 1, 1, 0, 3'b011);
    // R9 icon mode with both re-maps set and 1/16 requested
    set_cfg(0, 1, 1, 1, 1, 3'b001);
    set_cfg(1, 0, 0, 1, 1, 3'b110);
    // R10 display off while icon outputs keep running
    set_cfg(1, 0, 0, 0, 0, 3'b010);
    set_cfg(0, 1, 1, 0, 1, 3'b101);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule